// File: doc/BRIEF.md
# Register File Port Selector with Operand-A Bypass

This block sits between the decode and execute stages of a small three-stage 16-bit pipeline. Its job is to steer the register file. The file reads in one half of the clock and writes in the other. For that reason the two port-number outputs carry the decode-stage source registers while the phase input is high. While the phase input is low, they carry the execute-stage destination.

The block also produces the write enable for the result that is retiring. It flags a read-after-write hazard on the A operand, so that the A operand can take the result bus instead of the stale register value. The B operand is never bypassed. Hazards on port B are left to instruction scheduling.

All outputs are combinational. They are formed from the pipeline registers that surround the block and from the phase input.

Opcode encoding (4 bits):

| Code | Instruction |
|---|---|
| 0 | add |
| 1 | sub |
| 2 | add-immediate |
| 3 | register-register logic/carry |
| 4 to 7 | register-immediate logic/carry |
| 8 | load word |
| 9 | load byte |
| 10 | store word |
| 11 | store byte |
| 12 | jump-and-link |
| 13 | call |
| 14 | immediate prefix |
| 15 | branch |

Top module: `regport_ctrl`

## Requirements
- R1: With phase_hi = 1, port_a equals the dc_ra field for opcodes 0, 1, 2, 8, 9, 10, 11 and 12.
- R2: With phase_hi = 1, port_a equals the dc_rd field for opcodes 3 to 7, 14 and 15.
- R3: With phase_hi = 1 and dc_op = 13 (call), port_a is 0.
- R4: With phase_hi = 1, port_b equals dc_rd for the two store opcodes (10, 11) and dc_rb for every other opcode.
- R5: With phase_hi = 0, port_a and port_b both carry the write destination. That destination is 15 when ex_op = 13 and ex_rd otherwise.
- R6: wr_en is never 1 while advance is 0.
- R7: wr_en is 0 when ex_op is 10, 11, 14 or 15.
- R8: wr_en is 0 when ex_annul is 1 or when the write destination is register 0. In every other case with advance = 1, wr_en is 1.
- R9: fwd_a is 1 when the decode-stage port A source number equals the write destination and the execute instruction writes a result. This holds in either phase and regardless of advance.
- R10: fwd_a is 0 whenever the execute instruction writes nothing, whether it is annulled, a non-writing opcode, or targeting register 0.
- R11: A match between the port B source number and the write destination never raises fwd_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_hi | input | 1 | Register file phase: 1 = read half, 0 = write half |
| advance | input | 1 | Pipeline advance enable |
| dc_op | input | 4 | Decode-stage opcode |
| dc_rd | input | 4 | Decode-stage destination field |
| dc_ra | input | 4 | Decode-stage first source field |
| dc_rb | input | 4 | Decode-stage second source field |
| ex_op | input | 4 | Execute-stage opcode |
| ex_rd | input | 4 | Execute-stage destination field |
| ex_annul | input | 1 | Execute-stage instruction is annulled |
| port_a | output | 4 | Register file port A number |
| port_b | output | 4 | Register file port B number |
| wr_en | output | 1 | Register file write enable |
| fwd_a | output | 1 | Select result bus for the A operand |

## Verification
Some rules hold on every evaluation of the block, so the assertions check them continuously:
- a write enable never appears without advance and never targets register 0;
- both ports agree during the write half;
- call pins port A to register 0 when reading and to register 15 when writing;
- a bypass never comes from an annulled instruction.

The per-opcode choice between RA, RD and RB fields can only be shown by the bench's scenarios, which drive each opcode with distinct field values. The same holds for the exact set of non-writing opcodes and for the absence of any port B bypass.

// File: rtl/regsel_pkg.sv
// Package: shared widths, opcode codes and selector types for the
// register port selector. Assumes a 4-bit opcode and 16 registers.
package regsel_pkg;
    parameter int REG_W = 4;
    parameter int OP_W  = 4;

    localparam logic [REG_W-1:0] ZERO_REG = '0;
    localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

    parameter logic [OP_W-1:0] OP_ADD   = 4'd0;
    parameter logic [OP_W-1:0] OP_SUB   = 4'd1;
    parameter logic [OP_W-1:0] OP_ADDI  = 4'd2;
    parameter logic [OP_W-1:0] OP_RR    = 4'd3;
    parameter logic [OP_W-1:0] OP_LW    = 4'd8;
    parameter logic [OP_W-1:0] OP_LB    = 4'd9;
    parameter logic [OP_W-1:0] OP_SW    = 4'd10;
    parameter logic [OP_W-1:0] OP_SB    = 4'd11;
    parameter logic [OP_W-1:0] OP_JAL   = 4'd12;
    parameter logic [OP_W-1:0] OP_CALL  = 4'd13;
    parameter logic [OP_W-1:0] OP_IMM   = 4'd14;
    parameter logic [OP_W-1:0] OP_BR    = 4'd15;

    typedef enum logic [1:0] {ASRC_RA, ASRC_RD, ASRC_ZERO} asrc_e;
    typedef enum logic       {BSRC_RB, BSRC_RD}            bsrc_e;
endpackage

// File: rtl/regsel_decode.sv
// regsel_decode: picks the read-phase register numbers for ports A and B
// from the decode-stage instruction. Assumes opcodes from regsel_pkg;
// unlisted opcodes read RD on port A and RB on port B.
module regsel_decode
    import regsel_pkg::*;
(
    input  logic [OP_W-1:0]  dc_op,
    input  logic [REG_W-1:0] dc_rd,
    input  logic [REG_W-1:0] dc_ra,
    input  logic [REG_W-1:0] dc_rb,
    output logic [REG_W-1:0] rd_num_a,
    output logic [REG_W-1:0] rd_num_b
);
    asrc_e a_src;
    bsrc_e b_src;

    // Classify the opcode into port A and port B field sources.
    always_comb begin
        a_src = ASRC_RD;
        b_src = BSRC_RB;
        case (dc_op)
            OP_ADD, OP_SUB, OP_ADDI,
            OP_LW, OP_LB, OP_JAL:     a_src = ASRC_RA;
            OP_SW, OP_SB: begin
                a_src = ASRC_RA;
                b_src = BSRC_RD;
            end
            OP_CALL:                  a_src = ASRC_ZERO;
            default:                  a_src = ASRC_RD;
        endcase
    end

    // Turn the chosen sources into register numbers.
    always_comb begin
        case (a_src)
            ASRC_RA:   rd_num_a = dc_ra;
            ASRC_ZERO: rd_num_a = ZERO_REG;
            default:   rd_num_a = dc_rd;
        endcase
        rd_num_b = (b_src == BSRC_RD) ? dc_rd : dc_rb;
    end
endmodule

// File: rtl/regsel_exinfo.sv
// regsel_exinfo: derives the effective write destination of the execute
// instruction and whether it will really retire a result. Assumes that
// call always links into the top register.
module regsel_exinfo
    import regsel_pkg::*;
(
    input  logic [OP_W-1:0]  ex_op,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_annul,
    output logic [REG_W-1:0] wr_dest,
    output logic             res_valid
);
    logic makes_result;

    // Work out the destination and whether the opcode produces a value.
    always_comb begin
        wr_dest = (ex_op == OP_CALL) ? LINK_REG : ex_rd;
        case (ex_op)
            OP_SW, OP_SB, OP_IMM, OP_BR: makes_result = 1'b0;
            default:                     makes_result = 1'b1;
        endcase
    end

    // A result retires only if not annulled and not aimed at register 0.
    always_comb begin
        res_valid = makes_result && !ex_annul && (wr_dest != ZERO_REG);
    end
endmodule

// File: rtl/regsel_hazard.sv
// regsel_hazard: raises the A-operand bypass select when the decode-stage
// port A source is the register that the execute stage is about to write.
// Assumes res_valid already excludes annulled, non-writing and r0 cases.
module regsel_hazard
    import regsel_pkg::*;
(
    input  logic [REG_W-1:0] rd_num_a,
    input  logic [REG_W-1:0] wr_dest,
    input  logic             res_valid,
    output logic             fwd
);
    // Compare the source number against the live destination.
    always_comb begin
        fwd = res_valid && (rd_num_a == wr_dest);
    end
endmodule

// File: rtl/regport_ctrl.sv
// regport_ctrl: register file port numbering, write enable and A bypass.
// Ports carry decode sources while phase_hi is 1 and the execute
// destination while it is 0. Purely combinational; assumes the caller
// holds all inputs in pipeline registers.
module regport_ctrl
    import regsel_pkg::*;
(
    input  logic             phase_hi,
    input  logic             advance,
    input  logic [3:0]       dc_op,
    input  logic [3:0]       dc_rd,
    input  logic [3:0]       dc_ra,
    input  logic [3:0]       dc_rb,
    input  logic [3:0]       ex_op,
    input  logic [3:0]       ex_rd,
    input  logic             ex_annul,
    output logic [3:0]       port_a,
    output logic [3:0]       port_b,
    output logic             wr_en,
    output logic             fwd_a
);
    logic [REG_W-1:0] rd_num_a;
    logic [REG_W-1:0] rd_num_b;
    logic [REG_W-1:0] wr_dest;
    logic             res_valid;

    regsel_decode u_dec (
        .dc_op    (dc_op),
        .dc_rd    (dc_rd),
        .dc_ra    (dc_ra),
        .dc_rb    (dc_rb),
        .rd_num_a (rd_num_a),
        .rd_num_b (rd_num_b)
    );

    regsel_exinfo u_ex (
        .ex_op     (ex_op),
        .ex_rd     (ex_rd),
        .ex_annul  (ex_annul),
        .wr_dest   (wr_dest),
        .res_valid (res_valid)
    );

    regsel_hazard u_haz (
        .rd_num_a  (rd_num_a),
        .wr_dest   (wr_dest),
        .res_valid (res_valid),
        .fwd       (fwd_a)
    );

    // Time-multiplex the port numbers by phase; gate the write enable.
    always_comb begin
        port_a = phase_hi ? rd_num_a : wr_dest;
        port_b = phase_hi ? rd_num_b : wr_dest;
        wr_en  = advance && res_valid;
    end

    // Cross-module checks on the composed outputs.
    always_comb begin
        if (wr_en) begin
            assert_we_needs_adv_R6: assert (advance);
            assert_we_not_r0_R8: assert (ex_annul == 1'b0 && !(ex_op != OP_CALL && ex_rd == ZERO_REG));
        end
        if (!phase_hi) begin
            assert_write_phase_same_R5: assert (port_a == port_b);
        end
        if (!phase_hi && ex_op == OP_CALL) begin
            assert_call_writes_link_R5: assert (port_a == LINK_REG);
        end
        if (phase_hi && dc_op == OP_CALL) begin
            assert_call_reads_zero_R3: assert (port_a == ZERO_REG);
        end
        if (fwd_a) begin
            assert_no_fwd_annulled_R10: assert (!ex_annul);
        end
    end
endmodule

// File: tb/tb_regport_ctrl.sv
module tb_regport_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       phase_hi, advance, ex_annul;
    logic [3:0] dc_op, dc_rd, dc_ra, dc_rb, ex_op, ex_rd;
    logic [3:0] port_a, port_b;
    logic       wr_en, fwd_a;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    regport_ctrl dut (
        .phase_hi(phase_hi), .advance(advance),
        .dc_op(dc_op), .dc_rd(dc_rd), .dc_ra(dc_ra), .dc_rb(dc_rb),
        .ex_op(ex_op), .ex_rd(ex_rd), .ex_annul(ex_annul),
        .port_a(port_a), .port_b(port_b), .wr_en(wr_en), .fwd_a(fwd_a)
    );

    typedef struct packed {
        logic       ph;
        logic       adv;
        logic [3:0] dop, drd, dra, drb, eop, erd;
        logic       ann;
        logic [3:0] xa, xb;
        logic       xwe, xfwd;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1,1, 0, 1, 2,3,  0, 5, 0,  2, 3,1,0},
        '{1,1, 0, 1, 2,3,  0, 2, 0,  2, 3,1,1},
        '{1,1, 3, 4, 6,7,  4, 4, 0,  4, 7,1,1},
        '{1,1,10, 8, 9,1,  2, 8, 0,  9, 8,1,0},
        '{1,1,13, 3, 4,5,  0, 0, 0,  0, 5,0,0},
        '{0,1, 0, 1,15,3, 13, 2, 0, 15,15,1,1},
        '{0,1, 0, 1, 2,3,  8, 6, 0,  6, 6,1,0},
        '{1,1, 0, 1, 6,3, 10, 6, 0,  6, 3,0,0},
        '{1,1, 0, 1, 6,3, 14, 6, 0,  6, 3,0,0},
        '{1,1, 0, 1, 6,3, 15, 6, 0,  6, 3,0,0},
        '{1,1, 1, 1, 3,4,  0, 3, 1,  3, 4,0,0},
        '{1,0, 1, 1, 3,4,  0, 3, 0,  3, 4,0,1},
        '{1,1,12, 1,12,2, 12,14, 0, 12, 2,1,0},
        '{1,1, 9, 7, 5,0, 11, 5, 0,  5, 0,0,0},
        '{1,1,11, 7, 5,0,  5, 7, 0,  5, 7,1,0},
        '{1,1, 4, 0, 5,6,  4, 0, 0,  0, 6,0,0},
        '{0,1, 3, 1, 2,3,  3, 0, 0,  0, 0,0,0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        phase_hi = v.ph;  advance = v.adv;
        dc_op = v.dop;    dc_rd = v.drd; dc_ra = v.dra; dc_rb = v.drb;
        ex_op = v.eop;    ex_rd = v.erd; ex_annul = v.ann;
        #1;
    endtask

    // Requirement-level model of the read-phase A number.
    function automatic int exp_a_read(int op, int rd, int ra);
        if (op == 13) return 0;
        if (op <= 2 || (op >= 8 && op <= 12)) return ra;
        return rd;
    endfunction

    initial begin
        phase_hi = 1'b1; advance = 1'b0; ex_annul = 1'b0;
        dc_op = '0; dc_rd = '0; dc_ra = '0; dc_rb = '0; ex_op = '0; ex_rd = '0;
        #1;
        // Idle state: all-zero fields give no write and no bypass (R8, R10).
        chk("R8 idle wr_en", wr_en, 0);
        chk("R10 idle fwd_a", fwd_a, 0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            chk(TBL[i].ph ? "R1/R2/R3 port_a" : "R5 port_a", port_a, TBL[i].xa);
            chk(TBL[i].ph ? "R4 port_b" : "R5 port_b", port_b, TBL[i].xb);
            chk("R6/R7/R8 wr_en", wr_en, TBL[i].xwe);
            chk("R9/R10/R11 fwd_a", fwd_a, TBL[i].xfwd);
        end

        // Sweep every decode opcode in the read phase (R1 R2 R3 R4).
        for (int op = 0; op < 16; op++) begin
            vec_t v;
            v = '{1,1, op[3:0], 4'd1, 4'd2, 4'd3, 4'd15, 4'd9, 0, 0,0,0,0};
            drive(v);
            chk("R1/R2/R3 sweep port_a", port_a, exp_a_read(op, 1, 2));
            chk("R4 sweep port_b", port_b, (op == 10 || op == 11) ? 1 : 3);
        end

        // Sweep every execute opcode in the write phase (R5 R7).
        for (int op = 0; op < 16; op++) begin
            vec_t v;
            v = '{0,1, 4'd0, 4'd1, 4'd2, 4'd3, op[3:0], 4'd9, 0, 0,0,0,0};
            drive(v);
            chk("R5 sweep port_a", port_a, (op == 13) ? 15 : 9);
            chk("R5 sweep port_b", port_b, (op == 13) ? 15 : 9);
            chk("R7 sweep wr_en", wr_en, (op == 10 || op == 11 || op >= 14) ? 0 : 1);
        end

        // Corner: call aimed at rd 0 still writes r15 and bypasses a reader of r15 (R5, R9).
        drive('{1,1, 0, 4'd0, 4'd15, 4'd0, 4'd13, 4'd0, 0, 0,0,0,0});
        chk("R9 call link bypass", fwd_a, 1);
        chk("R8 call link write", wr_en, 1);

        // Corner: port B alone matches the destination (R11).
        drive('{1,1, 0, 4'd1, 4'd2, 4'd7, 4'd0, 4'd7, 0, 0,0,0,0});
        chk("R11 port B match", fwd_a, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule